// File: doc/BRIEF.md
# 4x4 Block-Compressed Pixel Decoder

This block sits in a display line fetch path and expands compressed 4x4 pixel regions into single pixels. Every region brings its own small colour table followed by one short selector per pixel. The selector picks an entry from that table. The block has two formats, and the format is chosen per region.

- **Indexed format:** the table holds four 8-bit palette indices and each selector is 2 bits wide. A colour lookup table further down the path resolves the indices.
- **True-colour format:** the table holds sixteen 24-bit colours and each selector is 4 bits wide. The colours pass to the output unchanged.

Compressed 32-bit words arrive on a valid/ready stream. The format select input is sampled together with the first word of each region. After the last word of a region is taken, the block sends the region's sixteen pixels one per accepted cycle on a second valid/ready stream. Each pixel carries its row and column within the region. Words for the next region are refused until the last pixel of the current region has been handed over.

Top module: `bcd_region_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_fmt`=0 (indexed) on the first word, a region is exactly 2 words long. Word 0 holds palette entry j at bits [8j+7:8j]. Word 1 holds the selector of pixel p at bits [2p+1:2p]. `out_valid` stays 0 after word 0 and is 1 on the cycle after word 1 is taken.
- R3: In indexed format, `out_value[7:0]` equals the palette entry named by the pixel's selector, and `out_value[23:8]` is 0.
- R4: With `in_fmt`=1 (true-colour) on the first word, a region is exactly 14 words long. Words 0 to 11 are concatenated with word k at bits [32k+31:32k], and colour c sits at bits [24c+23:24c] of the result. Words 12 and 13 form a 64-bit selector field, word 12 in the low half, with pixel p's selector at bits [4p+3:4p]. Each pixel's `out_value` is the colour its selector names.
- R5: The sixteen pixels leave in raster order, pixel p = 4*row + col. Pixel p carries `out_row` = p/4 and `out_col` = p%4.
- R6: `in_ready` is 0 from the cycle after a region's last word is taken until the last pixel's handshake. It returns to 1 on the following cycle, with `out_valid` back at 0.
- R7: `in_fmt` is sampled only with a region's first word. Changes on later words do not affect the region's length or its decoding. `out_truecol` shows the sampled format (1 = true-colour) for every pixel of the region.
- R8: While `out_valid` is 1 and `out_ready` is 0, the pixel, its row and its column hold steady.
- R9: Cycles with `in_valid` at 0 take no word and leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Compressed word |
| in_fmt | input | 1 | Format of a new region: 0 indexed, 1 true-colour |
| out_valid | output | 1 | Decoded pixel present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_value | output | 24 | Palette index (low 8 bits) or 24-bit colour |
| out_row | output | 2 | Row of the pixel in its region |
| out_col | output | 2 | Column of the pixel in its region |
| out_truecol | output | 1 | Format of the pixel's region |

## Verification
The checker assumes a downstream sink that may hold `out_ready` low for any number of cycles. It also assumes that word boundaries are set only by the valid/ready handshake, so `in_valid` may drop between words and `in_fmt` may change at any time. The bench keeps within these assumptions in three ways: it drives inputs only on falling edges, it inserts idle cycles between words, and it stalls the pixel stream on selected pixels. It also flips `in_fmt` after the first word on chosen regions. The selector patterns rotate from region to region so that every pixel position meets every table entry in both formats.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int WORD_W        = 32;
    localparam int DIM           = 4;
    localparam int NPIX          = DIM * DIM;
    localparam int POS_W         = $clog2(DIM);
    localparam int PIX_IDX_W     = $clog2(NPIX);
    localparam int LUT_SEL_W     = 2;
    localparam int LUT_COL_W     = 8;
    localparam int DIR_SEL_W     = 4;
    localparam int DIR_COL_W     = 24;
    localparam int OUT_W         = DIR_COL_W;
    localparam int LUT_NCOL      = 1 << LUT_SEL_W;
    localparam int DIR_NCOL      = 1 << DIR_SEL_W;
    localparam int COL_BITS      = DIR_NCOL * DIR_COL_W;
    localparam int SEL_BITS      = NPIX * DIR_SEL_W;
    localparam int LUT_HDR_WORDS = (LUT_NCOL * LUT_COL_W) / WORD_W;
    localparam int LUT_SEL_WORDS = (NPIX * LUT_SEL_W) / WORD_W;
    localparam int DIR_HDR_WORDS = COL_BITS / WORD_W;
    localparam int DIR_SEL_WORDS = SEL_BITS / WORD_W;
    localparam int MAX_WORDS     = DIR_HDR_WORDS + DIR_SEL_WORDS;
    localparam int WCNT_W        = $clog2(MAX_WORDS + 1);

    typedef enum logic {
        FMT_INDEXED = 1'b0,
        FMT_TRUECOL = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [COL_BITS-1:0] colours;
        logic [SEL_BITS-1:0] sels;
        fmt_e                fmt;
    } region_t;

    typedef struct packed {
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
        logic [OUT_W-1:0] value;
    } pix_t;

    function automatic logic [WCNT_W-1:0] hdr_words(fmt_e f);
        return (f == FMT_TRUECOL) ? WCNT_W'(DIR_HDR_WORDS) : WCNT_W'(LUT_HDR_WORDS);
    endfunction

    function automatic logic [WCNT_W-1:0] total_words(fmt_e f);
        return (f == FMT_TRUECOL) ? WCNT_W'(DIR_HDR_WORDS + DIR_SEL_WORDS)
                                  : WCNT_W'(LUT_HDR_WORDS + LUT_SEL_WORDS);
    endfunction
endpackage

// File: rtl/bcd_word_loader.sv
module bcd_word_loader
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_fmt,
    output logic              in_ready,
    input  logic              drain_done,
    output logic              full_o,
    output region_t           region_o
);
    logic [WCNT_W-1:0] wcnt_q;
    logic              full_q;
    fmt_e              fmt_q;
    fmt_e              cur_fmt;
    logic [WCNT_W-1:0] hdr_n;
    logic              take;
    logic              in_hdr;
    logic              last_word;
    logic [WORD_W-1:0] col_words [DIR_HDR_WORDS];
    logic [WORD_W-1:0] sel_words [DIR_SEL_WORDS];
    logic [COL_BITS-1:0] col_flat;
    logic [SEL_BITS-1:0] sel_flat;

    // The format pin matters only while the first word is on the bus.
    assign cur_fmt   = (wcnt_q == '0) ? fmt_e'(in_fmt) : fmt_q;
    assign hdr_n     = hdr_words(cur_fmt);
    assign in_hdr    = wcnt_q < hdr_n;
    assign last_word = wcnt_q == (total_words(cur_fmt) - WCNT_W'(1));
    assign take      = in_valid && !full_q;
    assign in_ready  = !full_q;
    assign full_o    = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            full_q <= 1'b0;
            fmt_q  <= FMT_INDEXED;
        end else begin
            if (take) begin
                fmt_q <= cur_fmt;
                if (last_word) begin
                    wcnt_q <= '0;
                    full_q <= 1'b1;
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
            if (drain_done) begin
                full_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DIR_HDR_WORDS; k++) col_words[k] <= '0;
            for (int s = 0; s < DIR_SEL_WORDS; s++) sel_words[s] <= '0;
        end else begin
            for (int k = 0; k < DIR_HDR_WORDS; k++) begin
                if (take && in_hdr && wcnt_q == WCNT_W'(k)) col_words[k] <= in_data;
            end
            for (int s = 0; s < DIR_SEL_WORDS; s++) begin
                if (take && !in_hdr && wcnt_q == hdr_n + WCNT_W'(s)) sel_words[s] <= in_data;
            end
        end
    end

    for (genvar k = 0; k < DIR_HDR_WORDS; k++) begin : g_col
        assign col_flat[k*WORD_W +: WORD_W] = col_words[k];
    end
    for (genvar s = 0; s < DIR_SEL_WORDS; s++) begin : g_sel
        assign sel_flat[s*WORD_W +: WORD_W] = sel_words[s];
    end

    assign region_o = '{colours: col_flat, sels: sel_flat, fmt: fmt_q};
endmodule

// File: rtl/bcd_pixel_pick.sv
module bcd_pixel_pick
    import bcd_pkg::*;
(
    input  region_t              region_i,
    input  logic [PIX_IDX_W-1:0] idx_i,
    output logic [OUT_W-1:0]     value_o
);
    logic [DIR_COL_W-1:0] dir_pal [DIR_NCOL];
    logic [LUT_COL_W-1:0] lut_pal [LUT_NCOL];
    logic [DIR_SEL_W-1:0] dir_sel [NPIX];
    logic [LUT_SEL_W-1:0] lut_sel [NPIX];

    for (genvar c = 0; c < DIR_NCOL; c++) begin : g_dpal
        assign dir_pal[c] = region_i.colours[c*DIR_COL_W +: DIR_COL_W];
    end
    for (genvar c = 0; c < LUT_NCOL; c++) begin : g_lpal
        assign lut_pal[c] = region_i.colours[c*LUT_COL_W +: LUT_COL_W];
    end
    for (genvar p = 0; p < NPIX; p++) begin : g_psel
        assign dir_sel[p] = region_i.sels[p*DIR_SEL_W +: DIR_SEL_W];
        assign lut_sel[p] = region_i.sels[p*LUT_SEL_W +: LUT_SEL_W];
    end

    always_comb begin
        if (region_i.fmt == FMT_TRUECOL) begin
            value_o = dir_pal[dir_sel[idx_i]];
        end else begin
            value_o = OUT_W'(lut_pal[lut_sel[idx_i]]);
        end
    end
endmodule

// File: rtl/bcd_emitter.sv
module bcd_emitter
    import bcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 full_i,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [PIX_IDX_W-1:0] idx_o,
    output logic                 done_o
);
    logic [PIX_IDX_W-1:0] idx_q;
    logic                 fire;
    logic                 last;

    assign out_valid = full_i;
    assign fire      = full_i && out_ready;
    assign last      = idx_q == PIX_IDX_W'(NPIX - 1);
    assign done_o    = fire && last;
    assign idx_o     = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/bcd_region_decoder.sv
module bcd_region_decoder
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_fmt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_value,
    output logic [POS_W-1:0]  out_row,
    output logic [POS_W-1:0]  out_col,
    output logic              out_truecol
);
    region_t              region;
    logic                 full;
    logic                 drain_done;
    logic [PIX_IDX_W-1:0] idx;
    logic [OUT_W-1:0]     value;
    pix_t                 pix;

    bcd_word_loader loader_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_fmt     (in_fmt),
        .in_ready   (in_ready),
        .drain_done (drain_done),
        .full_o     (full),
        .region_o   (region)
    );

    bcd_emitter emitter_i (
        .clk       (clk),
        .rst       (rst),
        .full_i    (full),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .idx_o     (idx),
        .done_o    (drain_done)
    );

    bcd_pixel_pick pick_i (
        .region_i (region),
        .idx_i    (idx),
        .value_o  (value)
    );

    assign pix = '{row: idx[PIX_IDX_W-1:POS_W], col: idx[POS_W-1:0], value: value};

    assign out_value   = pix.value;
    assign out_row     = pix.row;
    assign out_col     = pix.col;
    assign out_truecol = region.fmt;
endmodule

// File: rtl/bcd_region_decoder_chk.sv
module bcd_region_decoder_chk
    import bcd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_value,
    input logic [POS_W-1:0] out_row,
    input logic [POS_W-1:0] out_col,
    input logic             out_truecol
);
    logic last_fire;
    assign last_fire = out_valid && out_ready && (&out_row) && (&out_col);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_reopen_r6: assert property (@(posedge clk) disable iff (rst)
        last_fire |=> (in_ready && !out_valid));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_value) && $stable(out_row) && $stable(out_col)));

    p_raster_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !last_fire) |=>
            (out_valid && {out_row, out_col} == $past({out_row, out_col}) + 1'b1));

    p_fmt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !last_fire) |=> $stable(out_truecol));

    p_index_width_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_truecol) |-> (out_value[OUT_W-1:LUT_COL_W] == '0));
endmodule

bind bcd_region_decoder bcd_region_decoder_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_value   (out_value),
    .out_row     (out_row),
    .out_col     (out_col),
    .out_truecol (out_truecol)
);

// File: tb/bcd_region_decoder_tb.sv
`timescale 1ns/1ps
module bcd_region_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_fmt = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_value;
    logic [1:0]  out_row;
    logic [1:0]  out_col;
    logic        out_truecol;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    bcd_region_decoder dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_fmt      (in_fmt),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_value   (out_value),
        .out_row     (out_row),
        .out_col     (out_col),
        .out_truecol (out_truecol)
    );

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Drive one word at a falling edge and wait for the handshake.
    task automatic send_word(logic [31:0] w, logic fmt);
        in_valid = 1'b1;
        in_data  = w;
        in_fmt   = fmt;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic run_region(bit truecol, int t, int gap, bit stall, bit flip);
        logic [383:0] cf;
        logic [63:0]  sf;
        logic [31:0]  words [14];
        logic [23:0]  pal [16];
        int           sel [16];
        int           nw;
        logic [23:0]  exp_v;
        logic [23:0]  held;
        cf = '0;
        sf = '0;
        for (int c = 0; c < 16; c++) begin
            if (truecol) pal[c] = 24'(c * 70001 + t * 4099 + 1);
            else         pal[c] = 24'((c * 29 + t * 53 + 7) % 256);
        end
        for (int p = 0; p < 16; p++) begin
            if (truecol) begin
                sel[p] = (p * 3 + t) % 16;
                sf[4*p +: 4] = 4'(sel[p]);
            end else begin
                sel[p] = (p + t) % 4;
                sf[2*p +: 2] = 2'(sel[p]);
            end
        end
        if (truecol) begin
            for (int c = 0; c < 16; c++) cf[24*c +: 24] = pal[c];
            for (int k = 0; k < 12; k++) words[k] = cf[32*k +: 32];
            words[12] = sf[31:0];
            words[13] = sf[63:32];
            nw = 14;
        end else begin
            for (int c = 0; c < 4; c++) cf[8*c +: 8] = pal[c][7:0];
            words[0] = cf[31:0];
            words[1] = sf[31:0];
            nw = 2;
        end
        for (int k = 0; k < nw; k++) begin
            send_word(words[k], (k == 0 || !flip) ? truecol : !truecol);
            if (k < nw - 1) begin
                // R2/R4/R7/R9: region not complete yet, so no pixel may appear
                check(!out_valid && in_ready, truecol ? "R4 early output" : "R2 early output",
                      {out_valid, in_ready}, 2'b01);
                for (int g = 0; g < gap; g++) begin
                    in_fmt = !in_fmt;
                    @(negedge clk);
                end
                if (gap > 0) check(!out_valid, "R9 idle cycle counted", out_valid, 0);
            end else begin
                check(out_valid && !in_ready, truecol ? "R4 region length" : "R2 region length",
                      {out_valid, in_ready}, 2'b10);
            end
        end
        for (int p = 0; p < 16; p++) begin
            exp_v = truecol ? pal[sel[p]] : {16'h0, pal[sel[p]][7:0]};
            check(out_valid && !in_ready, "R6 busy while emitting", {out_valid, in_ready}, 2'b10);
            check(out_value == exp_v, truecol ? "R4 colour" : "R3 index", out_value, exp_v);
            check(out_row == 2'(p / 4) && out_col == 2'(p % 4), "R5 position",
                  {out_row, out_col}, 4'(p));
            check(out_truecol == truecol, "R7 format tag", out_truecol, truecol);
            if (stall && (p % 5 == 0)) begin
                out_ready = 1'b0;
                held = out_value;
                @(negedge clk);
                @(negedge clk);
                check(out_valid && out_value == held && out_row == 2'(p / 4) && out_col == 2'(p % 4),
                      "R8 stall hold", {out_valid, out_row, out_col, out_value},
                      {1'b1, 4'(p), held});
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        check(in_ready && !out_valid, "R6 reopen after last pixel", {in_ready, out_valid}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
        for (int t = 0; t < 4; t++) begin
            run_region(1'b0, t, t % 2, t == 1, t == 2);
        end
        for (int t = 0; t < 16; t++) begin
            run_region(1'b1, t, (t % 3 == 0) ? 2 : 0, t % 4 == 1, t % 5 == 2);
        end
        run_region(1'b0, 3, 1, 1'b1, 1'b1);
        run_region(1'b1, 7, 0, 1'b0, 1'b1);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule